// File: doc/BRIEF.md
# Readout Buffer Occupancy Emulator

This block keeps a running count of how many event buffers in a front-end readout pipeline hold data that has not yet been read out. Every trigger accept fills one buffer. Every finished output frame frees one buffer. A clear pulse empties the pipeline. The front end drains at a fixed, slow pace: one frame of 280 clock cycles. Triggers, however, can arrive every third cycle. For that reason the busy flag comes from a threshold that software programs. The threshold is set low enough that every trigger still in flight during the trigger round-trip delay finds a free buffer.

The end of a frame can come from two sources. One is a pulse on an input pin, driven by logic that watches the real readout. The other is an internal timer that reproduces the fixed frame length. The timer starts a frame as soon as any buffer is occupied. It runs frames back to back until the count reaches zero. The usable depth depends on the operating mode: 31 buffers in the long mode and 10 in the short mode. A trigger that finds every buffer full is not counted. Instead it latches an overflow error. A warn flag at a second, lower threshold gives the trigger controller an early indication.

Top module: `occ_emu_top`

## Requirements
- R1: A trigger pulse sampled on a clock edge raises `occ_o` by one after that same edge, and triggers on consecutive cycles are all counted.
- R2: With the internal frame source selected, `occ_o` falls by one on the 281st edge after the edge that sampled the trigger that made it nonzero. It then falls once every further 280 edges while it stays nonzero.
- R3: With the external frame source selected, each `frame_i` pulse lowers a nonzero `occ_o` by one after its edge. A pulse while `occ_o` is zero leaves it at zero.
- R4: A `clr_i` pulse sets `occ_o` to zero and clears `ovf_o` after its edge. It takes priority over any trigger or frame event on the same cycle.
- R5: Control bit 0 selects the depth: 0 gives 31 buffers, 1 gives 10. A trigger sampled while `occ_o` is at or above the depth is not counted, and it sets `ovf_o`. `ovf_o` stays set until a clear or a reset.
- R6: A counted trigger and an effective frame completion on the same edge leave `occ_o` unchanged.
- R7: `busy_o` is high exactly while `occ_o` is greater than or equal to the busy threshold.
- R8: `warn_o` is high exactly while `occ_o` is greater than or equal to the warn threshold. The warn threshold never exceeds the busy threshold. A warn write above the busy threshold stores the busy threshold. A busy write below the warn threshold also lowers the warn threshold to the written value.
- R9: Register writes use `cfg_we_i` and `cfg_addr_i`. Address 0 holds the busy threshold and address 1 the warn threshold, each taken from `cfg_wdata_i[4:0]`. Address 2 is control, where bit 0 is the short-depth mode and bit 1 selects the external frame source. After reset the busy threshold is 8, the warn threshold is 6, and control is 0.
- R10: `frame_i` has no effect while the internal source is selected. The internal timer never lowers the count while the external source is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bunch clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Trigger accept pulse |
| clr_i | input | 1 | Pipeline clear pulse |
| frame_i | input | 1 | Frame-completed pulse from external readout monitor |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| occ_o | output | 5 | Occupied buffer count |
| busy_o | output | 1 | Busy flag to trigger controller |
| warn_o | output | 1 | Early warning flag |
| ovf_o | output | 1 | Sticky overflow error |

## Verification
The count, overflow and clear results settle after the single edge that samples the stimulus. Busy and warn follow the count combinationally on that same edge. The bench therefore drives every input on a falling edge and reads the result on the next falling edge. The internal drain is due 281 edges after the first trigger and every 280 edges after that. So the bench counts falling edges from the trigger. It checks the count one edge before each expected drop and once more right after it. That catches a timer that is off by one in either direction.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic [1:0] {
    REG_BUSY = 2'd0,
    REG_WARN = 2'd1,
    REG_CTRL = 2'd2
  } occ_reg_e;

  // Next occupancy from current count and the cycle's events.
  function automatic int unsigned next_occ(int unsigned cur, logic inc,
                                           logic dec, logic clr);
    int unsigned v;
    v = cur;
    if (clr) begin
      v = 0;
    end else begin
      if (inc) v = v + 1;
      if (dec && cur != 0) v = v - 1;
    end
    return v;
  endfunction

  function automatic int unsigned min_u(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/occ_cfg_regs.sv
module occ_cfg_regs
  import occ_pkg::*;
#(
  parameter int CW       = 5,
  parameter int DW       = 8,
  parameter int BUSY_RST = 8,
  parameter int WARN_RST = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [CW-1:0] busy_thr,
  output logic [CW-1:0] warn_thr,
  output logic          mode_short,
  output logic          ext_src
);

  logic [CW-1:0] wval;
  assign wval = wdata[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_thr   <= CW'(BUSY_RST);
      warn_thr   <= CW'(WARN_RST);
      mode_short <= 1'b0;
      ext_src    <= 1'b0;
    end else if (we) begin
      case (addr)
        REG_BUSY: begin
          busy_thr <= wval;
          warn_thr <= CW'(min_u(int'(warn_thr), int'(wval)));
        end
        REG_WARN: warn_thr <= CW'(min_u(int'(wval), int'(busy_thr)));
        REG_CTRL: begin
          mode_short <= wdata[0];
          ext_src    <= wdata[1];
        end
        default: ;
      endcase
    end
  end

  AST_WARN_LE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    warn_thr <= busy_thr); // R8

endmodule

// File: rtl/occ_frame_timer.sv
module occ_frame_timer #(
  parameter int FRAME_LEN = 280
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic occ_nz,
  input  logic keep_going,
  output logic frame_done
);

  localparam int TW = $clog2(FRAME_LEN);

  logic          running;
  logic [TW-1:0] cnt;

  assign frame_done = running && en && (cnt == TW'(FRAME_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (clr || !en) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!running) begin
      if (occ_nz) begin
        running <= 1'b1;
        cnt     <= '0;
      end
    end else if (frame_done) begin
      running <= keep_going;
      cnt     <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R2

  AST_TIMER_QUIET_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !frame_done); // R10

endmodule

// File: rtl/occ_counter.sv
module occ_counter
  import occ_pkg::*;
#(
  parameter int MAX_DEPTH   = 31,
  parameter int SHORT_DEPTH = 10,
  parameter int CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          dec_evt,
  input  logic          clr,
  input  logic          mode_short,
  output logic [CW-1:0] occ,
  output logic          ovf,
  output logic          occ_nz,
  output logic          next_nz,
  output logic          inc_evt
);

  logic [CW-1:0] depth;
  logic          full;
  logic [CW-1:0] occ_nxt;

  assign depth   = mode_short ? CW'(SHORT_DEPTH) : CW'(MAX_DEPTH);
  assign full    = (occ >= depth);
  assign inc_evt = trig && !full;
  assign occ_nxt = CW'(next_occ(int'(occ), inc_evt, dec_evt, clr));
  assign occ_nz  = (occ != '0);
  assign next_nz = (occ_nxt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= '0;
      ovf <= 1'b0;
    end else begin
      occ <= occ_nxt;
      if (clr)               ovf <= 1'b0;
      else if (trig && full) ovf <= 1'b1;
    end
  end

  AST_INC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && !dec_evt && !clr) |=> occ == $past(occ) + 1'b1); // R1

  AST_DEC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_evt && !inc_evt && !clr && occ != '0) |=> occ == $past(occ) - 1'b1); // R2

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (occ == '0 && !ovf)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(MAX_DEPTH)); // R5

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf); // R5

  AST_FULL_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && full && !clr) |=> ovf); // R5

  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt && dec_evt && occ != '0 && !clr) |=> $stable(occ)); // R6

endmodule

// File: rtl/occ_emu_top.sv
module occ_emu_top #(
  parameter int MAX_DEPTH   = 31,
  parameter int SHORT_DEPTH = 10,
  parameter int FRAME_LEN   = 280,
  parameter int DW          = 8,
  parameter int BUSY_RST    = 8,
  parameter int WARN_RST    = 6,
  localparam int CW         = $clog2(MAX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          clr_i,
  input  logic          frame_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic [CW-1:0] occ_o,
  output logic          busy_o,
  output logic          warn_o,
  output logic          ovf_o
);

  logic [CW-1:0] busy_thr, warn_thr;
  logic          mode_short, ext_src;
  logic          timer_done, dec_evt;
  logic          occ_nz, next_nz, inc_evt;

  occ_cfg_regs #(
    .CW(CW), .DW(DW), .BUSY_RST(BUSY_RST), .WARN_RST(WARN_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .addr(cfg_addr_i),
    .wdata(cfg_wdata_i), .busy_thr(busy_thr), .warn_thr(warn_thr),
    .mode_short(mode_short), .ext_src(ext_src)
  );

  occ_frame_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr_i), .en(!ext_src),
    .occ_nz(occ_nz), .keep_going(next_nz), .frame_done(timer_done)
  );

  assign dec_evt = ext_src ? frame_i : timer_done;

  occ_counter #(
    .MAX_DEPTH(MAX_DEPTH), .SHORT_DEPTH(SHORT_DEPTH), .CW(CW)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .trig(trig_i), .dec_evt(dec_evt),
    .clr(clr_i), .mode_short(mode_short), .occ(occ_o), .ovf(ovf_o),
    .occ_nz(occ_nz), .next_nz(next_nz), .inc_evt(inc_evt)
  );

  assign busy_o = (occ_o >= busy_thr);
  assign warn_o = (occ_o >= warn_thr);

  AST_BUSY_HAS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> warn_o); // R8

  AST_EXT_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_src && frame_i && !timer_done && !inc_evt && !clr_i) |=> $stable(occ_o)); // R10

endmodule

// File: tb/tb_occ_emu_top.sv
module tb_occ_emu_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_i = 1'b0, clr_i = 1'b0, frame_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_addr_i = '0;
  logic [7:0] cfg_wdata_i = '0;
  logic [4:0] occ_o;
  logic       busy_o, warn_o, ovf_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  occ_emu_top dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .clr_i(clr_i),
    .frame_i(frame_i), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .occ_o(occ_o), .busy_o(busy_o),
    .warn_o(warn_o), .ovf_o(ovf_o)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic clear();
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0;
  endtask

  task automatic trigs(int n, int gap);
    for (int i = 0; i < n; i++) begin
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) begin
      frame_i = 1'b1;
      @(negedge clk);
      frame_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R9 reset occ", occ_o, 0);
    chk("R9 reset busy", busy_o, 0);
    chk("R9 reset warn", warn_o, 0);
    chk("R9 reset ovf", ovf_o, 0);
  endtask

  task automatic t_defaults();
    wr(2, 8'h02);              // external source, long depth
    trigs(5, 3);
    chk("R8 below default warn", warn_o, 0);
    trigs(1, 3);
    chk("R1 count after 6", occ_o, 6);
    chk("R9 default warn 6", warn_o, 1);
    chk("R7 below default busy", busy_o, 0);
    trigs(2, 3);
    chk("R9 default busy 8", busy_o, 1);
    clear();
  endtask

  task automatic t_inc();
    trig_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0;
    chk("R1 one edge latency", occ_o, 1);
    trigs(5, 1);
    chk("R1 back to back", occ_o, 6);
    clear();
  endtask

  task automatic t_thresholds();
    wr(0, 8'd4);
    wr(1, 8'd20);              // clamped to 4
    trigs(3, 2);
    chk("R8 warn at 3", warn_o, 0);
    chk("R7 busy at 3", busy_o, 0);
    trigs(1, 2);
    chk("R8 clamped warn at 4", warn_o, 1);
    chk("R7 busy at 4", busy_o, 1);
    clear();
    wr(0, 8'd2);               // lowers warn to 2
    trigs(1, 1);
    chk("R8 warn at 1", warn_o, 0);
    trigs(1, 1);
    chk("R8 warn follows busy write", warn_o, 1);
    chk("R7 busy at 2", busy_o, 1);
    clear();
    wr(0, 8'd8);
    wr(1, 8'd6);
  endtask

  task automatic t_depth();
    wr(2, 8'h03);              // short depth, external
    trigs(12, 3);
    chk("R5 short depth cap", occ_o, 10);
    chk("R5 overflow set", ovf_o, 1);
    repeat (5) @(negedge clk);
    chk("R5 overflow sticky", ovf_o, 1);
    clear();
    chk("R4 clear count", occ_o, 0);
    chk("R4 clear ovf", ovf_o, 0);
    wr(2, 8'h02);
    trigs(31, 1);
    chk("R5 long depth no ovf yet", ovf_o, 0);
    trigs(2, 1);
    chk("R5 long depth cap", occ_o, 31);
    chk("R5 long overflow", ovf_o, 1);
    trig_i = 1'b1; clr_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0; clr_i = 1'b0;
    chk("R4 clear beats trigger", occ_o, 0);
  endtask

  task automatic t_ext();
    trigs(3, 1);
    frames(1);
    chk("R3 frame decrement", occ_o, 2);
    frames(2);
    chk("R3 drained", occ_o, 0);
    frames(1);
    chk("R3 frame at zero", occ_o, 0);
    trigs(1, 1);
    repeat (600) @(negedge clk);
    chk("R10 no timer drain in external", occ_o, 1);
    clear();
  endtask

  task automatic t_same();
    trigs(2, 1);
    trig_i = 1'b1; frame_i = 1'b1;
    @(negedge clk);
    trig_i = 1'b0; frame_i = 1'b0;
    chk("R6 simultaneous events", occ_o, 2);
    clear();
  endtask

  task automatic t_internal();
    wr(2, 8'h00);
    clear();
    trig_i = 1'b1;
    @(negedge clk);            // E0
    @(negedge clk);            // E1
    trig_i = 1'b0;
    frame_i = 1'b1;
    @(negedge clk);            // E2
    frame_i = 1'b0;
    repeat (278) @(negedge clk); // E280
    chk("R10 frame pin ignored / R2 before drop", occ_o, 2);
    @(negedge clk);            // E281
    chk("R2 first drain at 281", occ_o, 1);
    repeat (279) @(negedge clk); // E560
    chk("R2 before second drain", occ_o, 1);
    @(negedge clk);            // E561
    chk("R2 second drain after 280", occ_o, 0);
    repeat (600) @(negedge clk);
    chk("R2 idle stays empty", occ_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_inc();
    t_thresholds();
    t_depth();
    t_ext();
    t_same();
    t_internal();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule